// File: doc/BRIEF.md
# Single-Wire Half-Duplex Parity UART

This block moves bytes over one shared, bidirectional data wire, the kind used by single-pin debug links. The host side offers a byte through a valid/ready handshake. The transmitter first holds the wire high for a guard interval, then sends the frame and releases the wire. The frame is a low start bit, the byte least significant bit first, an even-parity bit and two high stop bits. When the wire is not driven it floats high through its pull-up. The receiver watches for the wire to fall. It then times to the centre of the start bit and samples every later bit one bit period apart. It hands back the eight data bits with a one-cycle strobe.

The wire appears at the boundary as three signals. `line_in` is the observed level. `drive_en` turns the output driver on, and `drive_val` is the level driven while it is on. The bit period is a whole number of clock cycles, fixed by a parameter. Transmit and receive never overlap: a byte offered during a reception waits until that frame has been taken in.

Top module: `sw_parity_uart`

## Requirements
- R1: A transmitted frame is a start bit of 0, then data bits 0 through 7, then the parity bit, then two stop bits of 1. Each bit lasts CLKS_PER_BIT clock cycles on `drive_val` while `drive_en` is 1.
- R2: The parity bit is the XOR of the eight data bits. It is 1 exactly when the byte holds an odd number of ones.
- R3: The start bit does not begin at once. For GUARD_BITS×CLKS_PER_BIT cycles, starting the cycle after a byte is accepted, `drive_en` is 1 and `drive_val` is 1.
- R4: In the cycle after the last stop-bit cycle, `drive_en` returns to 0 and `tx_ready` returns to 1.
- R5: A byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` stays 0 from acceptance until the wire is released.
- R6: The receiver starts a frame on a low level of `line_in` while idle. It samples near each bit centre and presents data bit 0 in `rx_data[0]` through data bit 7 in `rx_data[7]`.
- R7: `rx_valid` is 1 for exactly one cycle per received frame, during the second stop bit. The parity and stop levels are read but not stored, so a wrong parity value still returns the data byte.
- R8: While a reception is in progress, `tx_ready` is 0 and `drive_en` stays 0. A pending `tx_valid` is accepted as soon as the frame is done, with `tx_ready` already 1 in the cycle `rx_valid` is 1.
- R9: While the block is driving the wire it does not receive its own frame, and `rx_valid` stays 0.
- R10: After reset, `drive_en` is 0, `tx_ready` is 1 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte on `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can accept a byte |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe, `rx_data` is new |
| line_in | input | 1 | Observed level of the shared wire |
| drive_en | output | 1 | 1 turns the wire driver on |
| drive_val | output | 1 | Level driven when `drive_en` is 1 |

## Verification
The bench checks the parity bit with bytes of odd, even, zero and full weight. A wrong parity polarity or a bit taken from the wrong end of the byte shows up as a mismatch at a bit centre. It measures the guard interval and the release cycle. A design that starts the frame at once or keeps driving after the stops fails those windows. A received frame carrying deliberately wrong parity must still return its data once. A design that stores the parity or drops the byte fails that test. A transmit request raised in the middle of a reception must keep the driver off until the strobe and then go out whole. A design without that exclusion drives over the incoming frame or loses the request.

// File: rtl/swu_pkg.sv
package swu_pkg;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_GUARD = 2'd1,
    TX_FRAME = 2'd2
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HALF = 2'd1,
    RX_BITS = 2'd2
  } rx_state_e;

  localparam int FRAME_BITS = 12;  // start + 8 data + parity + 2 stop
  localparam int LAST_RX    = 10;  // index of second stop sample after start

  function automatic logic even_parity(input logic [7:0] b);
    return ^b;
  endfunction

endpackage

// File: rtl/swu_sync.sv
module swu_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/swu_tx.sv
module swu_tx
  import swu_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int GUARD_BITS   = 2,
  parameter int CNT_W        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  output logic       busy,
  output logic       drive_en,
  output logic       drive_val
);
  localparam logic [CNT_W-1:0] GUARD_LD = CNT_W'(GUARD_BITS * CLKS_PER_BIT - 1);
  localparam logic [CNT_W-1:0] BIT_LD   = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [3:0]       LAST_BIT = 4'(FRAME_BITS - 1);

  tx_state_e              st_q, st_d;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [3:0]             bit_q, bit_d;
  logic [FRAME_BITS-1:0]  sh_q, sh_d;
  logic                   tick;

  assign tick = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    unique case (st_q)
      TX_IDLE: begin
        if (start) begin
          st_d  = TX_GUARD;
          cnt_d = GUARD_LD;
          bit_d = '0;
          sh_d  = {2'b11, even_parity(data), data, 1'b0};
        end
      end
      TX_GUARD: begin
        if (tick) begin
          st_d  = TX_FRAME;
          cnt_d = BIT_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      TX_FRAME: begin
        if (tick) begin
          if (bit_q == LAST_BIT) begin
            st_d = TX_IDLE;
          end else begin
            bit_d = bit_q + 1'b1;
            sh_d  = {1'b1, sh_q[FRAME_BITS-1:1]};
            cnt_d = BIT_LD;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
    end
  end

  assign busy      = (st_q != TX_IDLE);
  assign drive_en  = busy;
  assign drive_val = (st_q == TX_FRAME) ? sh_q[0] : 1'b1;
endmodule

// File: rtl/swu_rx.sv
module swu_rx
  import swu_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int CNT_W        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       line,
  output logic       busy,
  output logic [7:0] data,
  output logic       valid
);
  localparam logic [CNT_W-1:0] HALF_LD = CNT_W'(CLKS_PER_BIT / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LD  = CNT_W'(CLKS_PER_BIT - 1);
  localparam logic [3:0]       STOP2   = 4'(LAST_RX);

  rx_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic             vld_q, vld_d;
  logic             tick;

  assign tick = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (enable && !line) begin
          st_d  = RX_HALF;
          cnt_d = HALF_LD;
        end
      end
      RX_HALF: begin
        if (tick) begin
          st_d  = RX_BITS;
          cnt_d = BIT_LD;
          bit_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      RX_BITS: begin
        if (tick) begin
          if (bit_q < 4'd8) sh_d = {line, sh_q[7:1]};
          if (bit_q == STOP2) begin
            st_d  = RX_IDLE;
            vld_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            cnt_d = BIT_LD;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      sh_q  <= sh_d;
      vld_q <= vld_d;
    end
  end

  assign busy  = (st_q != RX_IDLE);
  assign data  = sh_q;
  assign valid = vld_q;
endmodule

// File: rtl/sw_parity_uart.sv
module sw_parity_uart #(
  parameter int CLKS_PER_BIT = 16,
  parameter int GUARD_BITS   = 2,
  parameter int CNT_W        = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] tx_data,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       line_in,
  output logic       drive_en,
  output logic       drive_val
);
  localparam int GUARD_CYC = GUARD_BITS * CLKS_PER_BIT;

  generate
    if (CLKS_PER_BIT < 4 || GUARD_CYC > (2 ** CNT_W) || CLKS_PER_BIT > (2 ** CNT_W)) begin : g_bad_cfg
      $error("sw_parity_uart: bit period outside supported counter range");
    end
  endgenerate

  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic line_s;
  logic tx_busy, rx_busy, tx_start, rx_en;

  swu_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_s_n),
    .d    (line_in),
    .q    (line_s)
  );

  assign tx_ready = !tx_busy && !rx_busy;
  assign tx_start = tx_valid && tx_ready;
  assign rx_en    = !tx_busy && !tx_start;

  swu_tx #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .GUARD_BITS  (GUARD_BITS),
    .CNT_W       (CNT_W)
  ) u_tx (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .start    (tx_start),
    .data     (tx_data),
    .busy     (tx_busy),
    .drive_en (drive_en),
    .drive_val(drive_val)
  );

  swu_rx #(
    .CLKS_PER_BIT(CLKS_PER_BIT),
    .CNT_W       (CNT_W)
  ) u_rx (
    .clk   (clk),
    .rst_n (rst_s_n),
    .enable(rx_en),
    .line  (line_s),
    .busy  (rx_busy),
    .data  (rx_data),
    .valid (rx_valid)
  );
endmodule

// File: rtl/swu_check.sv
module swu_check (
  input logic clk,
  input logic rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic drive_en,
  input logic drive_val,
  input logic tx_busy,
  input logic rx_busy
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_busy && rx_busy)); // R8

  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R7

  AST_GUARD_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> drive_val); // R3

  AST_ACCEPT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (drive_en && !tx_ready)); // R5

  AST_READY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !drive_en); // R4

  AST_NO_SELF_RX: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> !rx_valid); // R9
endmodule

bind sw_parity_uart swu_check u_chk (
  .clk      (clk),
  .rst_n    (rst_s_n),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .drive_en (drive_en),
  .drive_val(drive_val),
  .tx_busy  (tx_busy),
  .rx_busy  (rx_busy)
);

// File: tb/sw_parity_uart_test.sv
`timescale 1ns/1ps
module sw_parity_uart_test;
  localparam int N  = 16;
  localparam int G  = 2;
  localparam int GN = G * N;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       line_in;
  logic       drive_en;
  logic       drive_val;
  logic       host_line;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  assign line_in = drive_en ? drive_val : host_line;

  sw_parity_uart #(.CLKS_PER_BIT(N), .GUARD_BITS(G), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .line_in(line_in), .drive_en(drive_en), .drive_val(drive_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic fbit(input logic [7:0] b, input logic flip, input int k);
    if (k == 0) return 1'b0;
    if (k <= 8) return b[k-1];
    if (k == 9) return (^b) ^ flip;
    return 1'b1;
  endfunction

  // Follows a transmit that was accepted on the previous edge; now at index 0.
  task automatic tx_check(input logic [7:0] b);
    logic guard_ok = 1'b1;
    logic busy_ok  = 1'b1;
    logic self_rx  = 1'b0;
    for (int idx = 0; idx <= GN + 12 * N; idx++) begin
      if (idx < GN && !(drive_en && drive_val)) guard_ok = 1'b0;
      if (idx < GN + 12 * N && tx_ready) busy_ok = 1'b0;
      if (rx_valid) self_rx = 1'b1;
      if (idx >= GN && idx < GN + 12 * N && ((idx - GN) % N) == N / 2) begin
        int k = (idx - GN) / N;
        chk((k == 9) ? "R2 parity bit" : "R1 frame bit",
            {30'd0, drive_en, drive_val}, {30'd0, 1'b1, fbit(b, 1'b0, k)});
      end
      if (idx == GN + 12 * N) begin
        chk("R4 released drive_en", {31'd0, drive_en}, 32'd0);
        chk("R4 tx_ready back", {31'd0, tx_ready}, 32'd1);
      end
      if (idx < GN + 12 * N) @(negedge clk);
    end
    chk("R3 guard idle-high window", {31'd0, guard_ok}, 32'd1);
    chk("R5 tx_ready low while busy", {31'd0, busy_ok}, 32'd1);
    chk("R9 no self reception", {31'd0, self_rx}, 32'd0);
  endtask

  task automatic t_send(input logic [7:0] b);
    @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_check(b);
  endtask

  task automatic t_recv(input logic [7:0] b, input logic flip);
    int pulses = 0;
    int at = -1;
    logic [7:0] got = '0;
    logic ready_seen = 1'b0;
    @(negedge clk);
    for (int idx = 0; idx < 13 * N; idx++) begin
      host_line = (idx < 12 * N) ? fbit(b, flip, idx / N) : 1'b1;
      if (idx == 5 * N) ready_seen = tx_ready;
      if (rx_valid) begin
        pulses++;
        at  = idx;
        got = rx_data;
      end
      @(negedge clk);
    end
    host_line = 1'b1;
    chk("R7 one strobe per frame", pulses, 1);
    chk("R7 strobe in second stop bit", {31'd0, (at >= 11 * N && at < 12 * N + 4)}, 32'd1);
    chk(flip ? "R7 data kept despite bad parity" : "R6 received byte", {24'd0, got}, {24'd0, b});
    chk("R8 tx_ready low during reception", {31'd0, ready_seen}, 32'd0);
  endtask

  task automatic t_collide(input logic [7:0] rb, input logic [7:0] tb);
    logic drove = 1'b0;
    logic seen  = 1'b0;
    @(negedge clk);
    for (int idx = 0; idx < 13 * N && !seen; idx++) begin
      host_line = (idx < 12 * N) ? fbit(rb, 1'b0, idx / N) : 1'b1;
      if (idx == 3 * N) begin
        tx_data  = tb;
        tx_valid = 1'b1;
      end
      if (drive_en) drove = 1'b1;
      if (rx_valid) begin
        seen = 1'b1;
        chk("R6 byte received under pending tx", {24'd0, rx_data}, {24'd0, rb});
        chk("R8 tx_ready up at rx strobe", {31'd0, tx_ready}, 32'd1);
      end else begin
        @(negedge clk);
      end
    end
    host_line = 1'b1;
    chk("R8 strobe reached", {31'd0, seen}, 32'd1);
    chk("R8 no drive during reception", {31'd0, drove}, 32'd0);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_check(tb);
  endtask

  task automatic t_reset();
    rst_n     = 1'b0;
    tx_valid  = 1'b0;
    tx_data   = '0;
    host_line = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 drive_en after reset", {31'd0, drive_en}, 32'd0);
    chk("R10 tx_ready after reset", {31'd0, tx_ready}, 32'd1);
    chk("R10 rx_valid after reset", {31'd0, rx_valid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_send(8'hA5);
    t_send(8'h01);
    t_send(8'h00);
    t_send(8'hFF);
    t_recv(8'h3C, 1'b0);
    t_recv(8'hC1, 1'b1);
    t_recv(8'h80, 1'b0);
    t_collide(8'h5A, 8'h96);
    t_send(8'h7E);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule